// File: doc/BRIEF.md
# Burst-Two Quad-Rate SRAM Controller

This controller sits between on-chip logic and an external static memory that has one read data bus, one write data bus and a shared address bus. Every access to that memory moves a burst of two 18-bit words within one clock period. The user side offers one read port and one write port. Both can be accepted in the same cycle. A write carries a 36-bit payload and four byte-lane enables. A read returns a packed 36-bit word with a one-cycle valid pulse.

Inside the controller, `clk` rising is the memory's true clock edge and `clk` falling is its complementary clock edge. The controller launches each memory-side signal on the edge opposite to the one where the memory samples it. Shared buses that carry a different value in each half of the cycle come from a two-flop double-rate output cell. The controller captures read data on both edges. After a fixed latency it packs the two words, with the first word in the low half.

Top module: `qdrBurstCtrl`

## Requirements
- R1: `rdReady` and `wrReady` are low while `rstN` is low and in the first cycle after release. From the first rising edge after release they are high and stay high.
- R2: A read accepted at rising edge E drives `memRdSelN` low for the next cycle only. At rising edge E+1, `memAddr` equals the accepted `rdAddr`.
- R3: A write accepted at rising edge E drives `memWrSelN` low at rising edge E+1. At that edge `memD` equals `wrData[17:0]` and `memBwN` equals the inverse of `wrBe[1:0]`. At the falling edge that follows, `memAddr` equals `wrAddr`, `memD` equals `wrData[35:18]` and `memBwN` equals the inverse of `wrBe[3:2]`. Strobe bit 0 governs data bits 8:0 and bit 1 governs bits 17:9. A strobe value of 0 writes the lane.
- R4: In a cycle with no accepted read, `memRdSelN` is high at the next rising edge. In a cycle with no accepted write, `memWrSelN` is high and `memBwN` is 2'b11 at both edges of the next cycle.
- R5: A read and a write accepted in the same cycle both reach the memory at the same rising edge. A read issued together with a write to the same address returns the contents from before that write.
- R6: With read latency RD_LAT (default 2), the word on `memQ` at rising edge E+1+RD_LAT goes to `rdData[17:0]` and the word at the falling edge after it goes to `rdData[35:18]`. Here E is the acceptance edge. `rdValid` is high for exactly the one cycle after rising edge E+RD_LAT+2, once per accepted read, in order.
- R7: While `rstN` is low, `memRdSelN`, `memWrSelN` and both bits of `memBwN` are high and `rdValid` is low.
- R8: One read and one write are accepted every cycle with no gap. A read accepted the cycle after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising = true memory edge, falling = complementary edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read burst address |
| rdReady | output | 1 | Read request accepted when high |
| wrReq | input | 1 | Write request |
| wrAddr | input | ADDR_W | Write burst address |
| wrData | input | 2*WORD_W | Write payload, first word in low half |
| wrBe | input | 2*LANES | Byte-lane enables, active high, first word in low bits |
| wrReady | output | 1 | Write request accepted when high |
| rdData | output | 2*WORD_W | Packed read burst |
| rdValid | output | 1 | One-cycle strobe for rdData |
| memRdSelN | output | 1 | Memory read select, active low |
| memWrSelN | output | 1 | Memory write select, active low |
| memAddr | output | ADDR_W | Memory address, read half then write half |
| memD | output | WORD_W | Double-rate write data |
| memBwN | output | LANES | Double-rate byte-write strobes, active low |
| memQ | input | WORD_W | Double-rate read data |

## Verification
A behavioural memory with the same edge rules sits on the memory side. The first pattern writes every address of a 16-entry configuration with full lanes and reads each one back, which shows whether the address and data halves are swapped. A sweep over all sixteen lane masks on every address, with an unrelated read in the same cycle, separates the four lanes and both burst halves. Same-address reads alongside writes, and reads one cycle after writes, separate read-before-write from read-after-write ordering. Every returned word is checked against an arithmetic reference model for both value and arrival cycle, and the memory side counts accesses and idle-strobe violations.

// File: rtl/qbcPkg.sv
package qbcPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic rdTake;   // read request accepted this cycle
    logic wrTake;   // write request accepted this cycle
    logic wrLive;   // registered write command in flight to the memory
    logic rdDone;   // both halves of a read burst are captured
  } qbcStrobes_t;
endpackage

// File: rtl/qbcDdrOut.sv
// Double-rate output cell: q follows dRise after a rising edge and dFall
// after a falling edge. Two flops, one per edge, combined by XOR.
module qbcDdrOut #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dRise,
  input  logic [W-1:0] dFall,
  output logic [W-1:0] q
);
  logic [W-1:0] riseQ;
  logic [W-1:0] fallQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseQ <= RST_VAL;
    else       riseQ <= dRise ^ fallQ;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallQ <= '0;
    else       fallQ <= dFall ^ riseQ;
  end

  assign q = riseQ ^ fallQ;
endmodule

// File: rtl/qbcControl.sv
module qbcControl
  import qbcPkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReq,
  input  logic        wrReq,
  output logic        rdReady,
  output logic        wrReady,
  output logic        memRdSelN,
  output logic        memWrSelN,
  output logic        rdValid,
  output qbcStrobes_t strb
);
  localparam int PIPE_D = RD_LAT + 1;

  logic              runQ;
  logic              rdCmdQ;
  logic              wrCmdQ;
  logic [PIPE_D-1:0] rdPipeQ;
  logic              rdValidQ;
  logic              rdSelQ;
  logic              wrSelQ;
  logic              rdTake;
  logic              wrTake;

  assign rdTake = rdReq & runQ;
  assign wrTake = wrReq & runQ;

  // request stage and read-return tracking on the true edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      rdCmdQ   <= 1'b0;
      wrCmdQ   <= 1'b0;
      rdPipeQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      runQ     <= 1'b1;
      rdCmdQ   <= rdTake;
      wrCmdQ   <= wrTake;
      rdPipeQ  <= {rdPipeQ[PIPE_D-2:0], rdCmdQ};
      rdValidQ <= rdPipeQ[RD_LAT];
    end
  end

  // selects launched half a cycle ahead of the true edge that samples them
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSelQ <= 1'b1;
      wrSelQ <= 1'b1;
    end else begin
      rdSelQ <= ~rdCmdQ;
      wrSelQ <= ~wrCmdQ;
    end
  end

  assign rdReady     = runQ;
  assign wrReady     = runQ;
  assign memRdSelN   = rdSelQ;
  assign memWrSelN   = wrSelQ;
  assign rdValid     = rdValidQ;
  assign strb.rdTake = rdTake;
  assign strb.wrTake = wrTake;
  assign strb.wrLive = wrCmdQ;
  assign strb.rdDone = rdPipeQ[RD_LAT];
endmodule

// File: rtl/qbcDatapath.sv
module qbcDatapath
  import qbcPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  qbcStrobes_t           strb,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [2*WORD_W-1:0]   wrData,
  input  logic [2*LANES-1:0]    wrBe,
  output logic [2*WORD_W-1:0]   rdData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memD,
  output logic [LANES-1:0]      memBwN,
  input  logic [WORD_W-1:0]     memQ
);
  localparam int BURST_W = 2 * WORD_W;

  logic [ADDR_W-1:0]  rdAddrQ;
  logic [ADDR_W-1:0]  wrAddrQ;
  logic [BURST_W-1:0] wrDataQ;
  logic [2*LANES-1:0] wrBeQ;
  logic [WORD_W-1:0]  qRiseQ;
  logic [WORD_W-1:0]  qFallQ;
  logic [BURST_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
      wrBeQ   <= '0;
      qRiseQ  <= '0;
      rdDataQ <= '0;
    end else begin
      if (strb.rdTake) rdAddrQ <= rdAddr;
      if (strb.wrTake) begin
        wrAddrQ <= wrAddr;
        wrDataQ <= wrData;
        wrBeQ   <= wrBe;
      end
      qRiseQ <= memQ;
      if (strb.rdDone) rdDataQ <= {qFallQ, qRiseQ};
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) qFallQ <= '0;
    else       qFallQ <= memQ;
  end

  // address: read address for the true edge, write address for the complement
  qbcDdrOut #(.W(ADDR_W), .RST_VAL('0)) addrOut (
    .clk(clk), .rstN(rstN),
    .dRise(wrAddrQ), .dFall(rdAddrQ), .q(memAddr)
  );

  // data: first word for the true edge, second for the complement
  qbcDdrOut #(.W(WORD_W), .RST_VAL('0)) dataOut (
    .clk(clk), .rstN(rstN),
    .dRise(wrDataQ[BURST_W-1:WORD_W]), .dFall(wrDataQ[WORD_W-1:0]), .q(memD)
  );

  // byte-write strobes, one double-rate cell per lane, idle high
  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic bwFirst;
    logic bwSecond;
    assign bwFirst  = strb.wrLive ? ~wrBeQ[l]       : 1'b1;
    assign bwSecond = strb.wrLive ? ~wrBeQ[LANES+l] : 1'b1;
    qbcDdrOut #(.W(1), .RST_VAL(1'b1)) bwOut (
      .clk(clk), .rstN(rstN),
      .dRise(bwSecond), .dFall(bwFirst), .q(memBwN[l])
    );
  end

  assign rdData = rdDataQ;
endmodule

// File: rtl/qdrBurstCtrl.sv
module qdrBurstCtrl
  import qbcPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 18,
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdReq,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic                rdReady,
  input  logic                wrReq,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [2*WORD_W-1:0] wrData,
  input  logic [2*LANES-1:0]  wrBe,
  output logic                wrReady,
  output logic [2*WORD_W-1:0] rdData,
  output logic                rdValid,
  output logic                memRdSelN,
  output logic                memWrSelN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memD,
  output logic [LANES-1:0]    memBwN,
  input  logic [WORD_W-1:0]   memQ
);
  qbcStrobes_t strb;

  qbcControl #(.RD_LAT(RD_LAT)) ctrl (
    .clk(clk), .rstN(rstN),
    .rdReq(rdReq), .wrReq(wrReq),
    .rdReady(rdReady), .wrReady(wrReady),
    .memRdSelN(memRdSelN), .memWrSelN(memWrSelN),
    .rdValid(rdValid), .strb(strb)
  );

  qbcDatapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .rdData(rdData), .memAddr(memAddr), .memD(memD), .memBwN(memBwN),
    .memQ(memQ)
  );
endmodule

// File: rtl/qbcChecker.sv
module qbcChecker #(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdReq,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic                rdReady,
  input logic                wrReq,
  input logic [2*WORD_W-1:0] wrData,
  input logic [2*LANES-1:0]  wrBe,
  input logic                wrReady,
  input logic                rdValid,
  input logic                memRdSelN,
  input logic                memWrSelN,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [WORD_W-1:0]   memD,
  input logic [LANES-1:0]    memBwN
);
  // R7
  always @(posedge clk) begin
    if (!rstN) begin
      rst_idle_chk: assert (memRdSelN && memWrSelN && (memBwN == '1) && !rdValid);
    end
  end

  // R1
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> (rdReady && wrReady));

  // R2
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdReady) |=> (!memRdSelN && (memAddr == $past(rdAddr))));

  // R4
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && rdReady) |=> memRdSelN);

  // R3
  wr_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrReady) |=> (!memWrSelN && (memD == $past(wrData[WORD_W-1:0]))
                           && (memBwN == ~$past(wrBe[LANES-1:0]))));

  // R4
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrReq && wrReady) |=> (memWrSelN && (memBwN == '1)));

  // R5
  pair_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdReady && wrReq && wrReady) |=> (!memRdSelN && !memWrSelN));
endmodule

bind qdrBurstCtrl qbcChecker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady),
  .wrReq(wrReq), .wrData(wrData), .wrBe(wrBe), .wrReady(wrReady),
  .rdValid(rdValid), .memRdSelN(memRdSelN), .memWrSelN(memWrSelN),
  .memAddr(memAddr), .memD(memD), .memBwN(memBwN)
);

// File: tb/tb_qdrBurstCtrl.sv
module tb_qdrBurstCtrl;
  localparam int TB_AW  = 4;
  localparam int TB_LAT = 2;
  localparam int DEPTH  = 1 << TB_AW;

  logic              clk = 1'b0;
  logic              rstN = 1'b1;
  logic              rdReq = 1'b0;
  logic [TB_AW-1:0]  rdAddr = '0;
  logic              rdReady;
  logic              wrReq = 1'b0;
  logic [TB_AW-1:0]  wrAddr = '0;
  logic [35:0]       wrData = '0;
  logic [3:0]        wrBe = '0;
  logic              wrReady;
  logic [35:0]       rdData;
  logic              rdValid;
  logic              memRdSelN;
  logic              memWrSelN;
  logic [TB_AW-1:0]  memAddr;
  logic [17:0]       memD;
  logic [1:0]        memBwN;
  logic [17:0]       memQ = '0;

  always #2.5 clk = ~clk;

  qdrBurstCtrl #(.ADDR_W(TB_AW), .WORD_W(18), .LANES(2), .RD_LAT(TB_LAT)) dut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .memRdSelN(memRdSelN), .memWrSelN(memWrSelN),
    .memAddr(memAddr), .memD(memD), .memBwN(memBwN), .memQ(memQ)
  );

  // counters owned by the stimulus process
  int checks = 0;
  int errors = 0;
  // counters owned by the memory/monitor process
  int mChecks = 0;
  int mErrs = 0;
  int cyc = 0;
  int memRdCnt = 0;
  int memWrCnt = 0;
  int nRd = 0;
  int nWr = 0;
  bit wdFired = 1'b0;

  logic [35:0] expMem [DEPTH];
  logic [35:0] expQ [$];
  int          cycQ [$];

  // behavioural memory
  logic [17:0] m0 [DEPTH];
  logic [17:0] m1 [DEPTH];
  logic        pWr;
  logic [17:0] pD0;
  logic [1:0]  pB0;
  logic        sV  [TB_LAT];
  logic [17:0] sW0 [TB_LAT];
  logic [17:0] sW1 [TB_LAT];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      expMem[i] = '0; m0[i] = '0; m1[i] = '0;
    end
    for (int i = 0; i < TB_LAT; i++) begin
      sV[i] = 1'b0; sW0[i] = '0; sW1[i] = '0;
    end
    pWr = 1'b0; pD0 = '0; pB0 = '1;
  end

  function automatic logic [17:0] mergeW(logic [17:0] oldW, logic [17:0] newW, logic [1:0] bwN);
    logic [17:0] r = oldW;
    for (int l = 0; l < 2; l++) if (!bwN[l]) r[l*9 +: 9] = newW[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] merge36(logic [35:0] oldW, logic [35:0] newW, logic [3:0] be);
    logic [35:0] r = oldW;
    for (int l = 0; l < 4; l++) if (be[l]) r[l*9 +: 9] = newW[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] pat(int a, int k);
    return 36'(a) * 36'h1_0203 + 36'(k) * 36'h9_1357 + 36'h5_0000_0001;
  endfunction

  // memory model and read-return monitor in one process (both edges)
  always @(posedge clk or negedge clk) begin
    if (clk) begin
      cyc <= cyc + 1;
      if (rstN) begin
        pWr <= !memWrSelN;
        pD0 <= memD;
        pB0 <= memBwN;
        if (!memWrSelN) memWrCnt <= memWrCnt + 1;
        else begin
          mChecks <= mChecks + 1;
          // R4: idle first-half strobes are high
          if (memBwN != 2'b11) begin
            mErrs <= mErrs + 1;
            $display("FAIL R4 first-half strobes idle act=%b exp=11", memBwN);
          end
        end
        if (sV[TB_LAT-1]) memQ <= sW1[TB_LAT-1];
        for (int i = TB_LAT - 1; i > 0; i--) begin
          sV[i] <= sV[i-1]; sW0[i] <= sW0[i-1]; sW1[i] <= sW1[i-1];
        end
        sV[0] <= !memRdSelN;
        sW0[0] <= m0[memAddr];
        sW1[0] <= m1[memAddr];
        if (!memRdSelN) memRdCnt <= memRdCnt + 1;
      end
    end else begin
      if (rstN) begin
        if (pWr) begin
          m0[memAddr] <= mergeW(m0[memAddr], pD0, pB0);
          m1[memAddr] <= mergeW(m1[memAddr], memD, memBwN);
        end else begin
          mChecks <= mChecks + 1;
          // R4: idle second-half strobes are high
          if (memBwN != 2'b11) begin
            mErrs <= mErrs + 1;
            $display("FAIL R4 second-half strobes idle act=%b exp=11", memBwN);
          end
        end
        pWr <= 1'b0;
        if (sV[TB_LAT-1]) memQ <= sW0[TB_LAT-1];
        if (rdValid) begin
          mChecks <= mChecks + 1;
          if (expQ.size() == 0) begin
            mErrs <= mErrs + 1;
            $display("FAIL R6 unexpected rdValid act=%h exp=none", rdData);
          end else begin
            logic [35:0] e;
            int ec;
            e = expQ.pop_front();
            ec = cycQ.pop_front();
            // R5 R6 R8: value and arrival cycle of each read
            if (rdData !== e || cyc != ec) begin
              mErrs <= mErrs + 1;
              $display("FAIL R6 read data/cycle act=%h@%0d exp=%h@%0d", rdData, cyc, e, ec);
            end
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic doCycle(bit re, int ra, bit we, int wa, logic [35:0] wd, logic [3:0] wb);
    rdReq  = re;
    rdAddr = TB_AW'(ra);
    wrReq  = we;
    wrAddr = TB_AW'(wa);
    wrData = wd;
    wrBe   = wb;
    if (re) begin
      expQ.push_back(expMem[ra]);
      cycQ.push_back(cyc + 1 + TB_LAT + 2);
      nRd++;
    end
    if (we) begin
      expMem[wa] = merge36(expMem[wa], wd, wb);
      nWr++;
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin : mainFlow
        #1 rstN = 1'b0;
        #2;
        // R7 R1: reset state
        chk(memRdSelN && memWrSelN, "R7 selects high in reset", {34'd0, memRdSelN, memWrSelN}, 36'h3);
        chk(memBwN == 2'b11, "R7 strobes high in reset", {34'd0, memBwN}, 36'h3);
        chk(!rdValid, "R7 rdValid low in reset", {35'd0, rdValid}, 36'h0);
        chk(!rdReady && !wrReady, "R1 ready low in reset", {34'd0, rdReady, wrReady}, 36'h0);
        repeat (3) @(posedge clk);
        #1 rstN = 1'b1;
        #1;
        chk(!rdReady && !wrReady, "R1 ready low before first edge", {34'd0, rdReady, wrReady}, 36'h0);
        @(posedge clk);
        #1;
        chk(rdReady && wrReady, "R1 ready high after release", {34'd0, rdReady, wrReady}, 36'h3);

        // full-lane writes then back-to-back reads (R3 R6 R8)
        for (int a = 0; a < DEPTH; a++) doCycle(0, 0, 1, a, pat(a, 0), 4'hF);
        for (int a = 0; a < DEPTH; a++) doCycle(1, a, 0, 0, '0, 4'h0);

        // every lane mask on every address with an unrelated read alongside (R3 R5)
        for (int m = 0; m < 16; m++)
          for (int a = 0; a < DEPTH; a++)
            doCycle(1, (a + 5) % DEPTH, 1, a, pat(a, m + 1), 4'(m));
        for (int a = 0; a < DEPTH; a++) doCycle(1, a, 0, 0, '0, 4'h0);

        // R5: read and write of the same address in one cycle
        for (int a = 0; a < DEPTH; a++) doCycle(1, a, 1, a, pat(a, 40), 4'(a ^ 9));
        // R8: write then read of the same address on the next cycle
        for (int a = 0; a < DEPTH; a++) begin
          doCycle(0, 0, 1, a, pat(a, 50), 4'hF);
          doCycle(1, a, 0, 0, '0, 4'h0);
        end
        doCycle(0, 0, 0, 0, '0, 4'h0);
        repeat (12) @(posedge clk);
        #1;
        chk(rdReady && wrReady, "R1 ready stays high", {34'd0, rdReady, wrReady}, 36'h3);
        chk(expQ.size() == 0, "R6 every read returned", 36'(expQ.size()), 36'h0);
        chk(memRdCnt == nRd, "R2 memory read count", 36'(memRdCnt), 36'(nRd));
        chk(memWrCnt == nWr, "R3 memory write count", 36'(memWrCnt), 36'(nWr));
        chk(memRdSelN && memWrSelN, "R4 selects high when idle", {34'd0, memRdSelN, memWrSelN}, 36'h3);
      end
      begin
        #200000;
        wdFired = 1'b1;
      end
    join_any
    disable fork;
    if (wdFired) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
    end
    checks += mChecks;
    errors += mErrs;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule